// File: doc/BRIEF.md
# Feed-Sequenced Watchdog Timer

This block is a watchdog counter that software controls through a small word-wide register bus. The bus has an address, a write strobe, a read strobe, write data and combinational read data. Software loads a timeout constant and then arms the counter. After that, software must keep reloading the counter with a strict two-write feed sequence. If the counter is allowed to run out, the block does four things: it records the event in two status flags, raises a level interrupt, stops itself, and, when reset-enable is set, issues a one-cycle chip-reset request.

Changes to the mode register do not act at once. They are parked until the next valid feed sequence completes. The run and reset-enable bits can only ever be set by software. There are two reset inputs. One is the power-on/brown-out reset. The other stands for any other reset source. The timeout flag survives the second kind, so software can still tell that the watchdog fired after the chip came back up.

Top module: `wdt_feed_ctrl`

## Requirements
- R1: Byte offsets: 0x0 is mode/status, 0x4 is the timeout constant, 0x8 is the feed register and 0xC is the counter value. Mode reads as {28'b0, int flag (bit 3), timeout flag (bit 2), reset-enable (bit 1), run (bit 0)}. The feed register and every other offset read as zero.
- R2: A feed write with low byte 0xAA, followed by a feed write with low byte 0x55 and no other bus access in between, reloads the counter from the timeout constant on the second write. If that second write falls in the same cycle as a timeout, the reload wins and no timeout occurs.
- R3: Run (bit 0) and reset-enable (bit 1) written to mode have no effect until the next valid feed completes. At that point they are applied.
- R4: Run and reset-enable can be set by software but not cleared. Writing 0 to them leaves them unchanged.
- R5: The prescaler runs freely and gives one tick every 4 clocks. While run is set, each tick decrements the counter. A tick that finds the counter at zero is a timeout. A timeout clears run and reset-enable and reloads the counter from the constant.
- R6: The timeout flag (mode bit 2) is set by a timeout. Writing 0 to bit 2 clears it immediately, without waiting for a feed. Writing 1 has no effect. Only the power-on reset clears it.
- R7: The interrupt flag (mode bit 3) is set by a timeout and cannot be written. Either reset clears it. The `irq` output equals this flag.
- R8: At a timeout with reset-enable set, `chip_rst_req` is high for exactly one cycle. It is never high otherwise.
- R9: A constant write below 0xFF stores 0xFF. The constant and the counter both reset to 0xFF.
- R10: After a 0xAA feed write, the sequence is abandoned without a reload if the next access is a read, a write to another register, or a feed write with any low byte other than 0x55. A pending mode write stays pending through an abandoned sequence.
- R11: The other-reset input clears everything except the timeout flag. The power-on reset clears everything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_por_n | input | 1 | Synchronous power-on/brown-out reset, active low |
| rst_sys_n | input | 1 | Synchronous reset from any other source, active low |
| addr | input | 4 | Register byte offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; counts as an access for the feed sequence |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Level interrupt, high while the interrupt flag is set |
| chip_rst_req | output | 1 | One-cycle chip-reset request |

## Verification
The assertions assume that `wr_en` and `rd_en` never target the same cycle with different meanings. They also assume that every access lasts exactly one cycle, so a single feed write is never counted twice. The stimulus issues one single-cycle access at a time, with idle cycles between accesses. It does not write mode in the cycle of a timeout. Both resets are held for at least two cycles, so the prescaler and the feed state always start from a known phase.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int OFS_MODE  = 0;
    localparam int OFS_CONST = 4;
    localparam int OFS_FEED  = 8;
    localparam int OFS_VALUE = 12;

    localparam logic [7:0] KEY_ARM  = 8'hAA;
    localparam logic [7:0] KEY_FIRE = 8'h55;

    localparam int MB_RUN   = 0;
    localparam int MB_RSTEN = 1;
    localparam int MB_TOF   = 2;
    localparam int MB_INT   = 3;

    typedef enum logic {FS_IDLE, FS_ARMED} feed_st_e;
endpackage

// File: rtl/wdt_tick_div.sv
module wdt_tick_div #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic clr,
    output logic tick
);
    localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;

    logic [PW-1:0] pre_d, pre_q;

    always_comb begin
        tick  = (pre_q == PW'(DIV - 1));
        pre_d = tick ? '0 : pre_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (clr) pre_q <= '0;
        else     pre_q <= pre_d;
    end

    // R5: ticks are spaced by the division ratio, never back to back
    p_tick_spacing_r5: assert property (@(posedge clk) disable iff (clr)
        tick |=> !tick);
endmodule

// File: rtl/wdt_feed_seq.sv
module wdt_feed_seq
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       clr,
    input  logic       acc,
    input  logic       feed_wr,
    input  logic [7:0] feed_byte,
    output logic       fire
);
    feed_st_e st_d, st_q;

    always_comb begin
        fire = (st_q == FS_ARMED) && feed_wr && (feed_byte == KEY_FIRE);
        st_d = st_q;
        if (acc) st_d = (feed_wr && feed_byte == KEY_ARM) ? FS_ARMED : FS_IDLE;
    end

    always_ff @(posedge clk) begin
        if (clr) st_q <= FS_IDLE;
        else     st_q <= st_d;
    end

    // R10: a read between the two keys can never be followed by a completion
    p_read_breaks_r10: assert property (@(posedge clk) disable iff (clr)
        (acc && !feed_wr) |=> !fire);
endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter #(
    parameter int W       = 32,
    parameter int RST_VAL = 255
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         run,
    input  logic         tick,
    input  logic         reload,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         expire
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        expire = run && tick && (cnt_q == '0) && !reload;
        cnt_d  = cnt_q;
        if (reload || expire) cnt_d = load_val;
        else if (run && tick) cnt_d = cnt_q - 1'b1;
        cnt = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (clr) cnt_q <= W'(RST_VAL);
        else     cnt_q <= cnt_d;
    end

    // R2: a completed feed loads the constant
    p_reload_r2: assert property (@(posedge clk) disable iff (clr)
        reload |=> cnt_q == $past(load_val));
    // R5: the counter holds while stopped and not reloaded
    p_hold_idle_r5: assert property (@(posedge clk) disable iff (clr)
        (!run && !reload) |=> $stable(cnt_q));
endmodule

// File: rtl/wdt_feed_ctrl.sv
module wdt_feed_ctrl
    import wdt_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 32,
    parameter int PRESCALE = 4,
    parameter int TC_MIN   = 255
) (
    input  logic              clk,
    input  logic              rst_por_n,
    input  logic              rst_sys_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq,
    output logic              chip_rst_req
);
    localparam logic [DATA_W-1:0] TC_FLOOR = DATA_W'(TC_MIN);

    typedef struct packed {
        logic              run;
        logic              rsten;
        logic              tof;
        logic              intf;
        logic              pend_run;
        logic              pend_rsten;
        logic              req;
        logic [DATA_W-1:0] tc;
    } wdt_state_t;

    localparam wdt_state_t S_INIT = '{run: 1'b0, rsten: 1'b0, tof: 1'b0, intf: 1'b0,
                                      pend_run: 1'b0, pend_rsten: 1'b0, req: 1'b0,
                                      tc: TC_FLOOR};

    wdt_state_t s_d, s_q;

    logic              clr_any;
    logic              tick, fire, expire;
    logic              mode_wr, const_wr, feed_wr, acc;
    logic [DATA_W-1:0] cnt;

    assign clr_any  = !rst_por_n || !rst_sys_n;
    assign acc      = wr_en || rd_en;
    assign mode_wr  = wr_en && (addr == ADDR_W'(OFS_MODE));
    assign const_wr = wr_en && (addr == ADDR_W'(OFS_CONST));
    assign feed_wr  = wr_en && (addr == ADDR_W'(OFS_FEED));

    wdt_tick_div #(.DIV(PRESCALE)) u_div (
        .clk (clk),
        .clr (clr_any),
        .tick(tick)
    );

    wdt_feed_seq u_feed (
        .clk      (clk),
        .clr      (clr_any),
        .acc      (acc),
        .feed_wr  (feed_wr),
        .feed_byte(wr_data[7:0]),
        .fire     (fire)
    );

    wdt_down_counter #(.W(DATA_W), .RST_VAL(TC_MIN)) u_cnt (
        .clk     (clk),
        .clr     (clr_any),
        .run     (s_q.run),
        .tick    (tick),
        .reload  (fire),
        .load_val(s_q.tc),
        .cnt     (cnt),
        .expire  (expire)
    );

    always_comb begin
        s_d     = s_q;
        s_d.req = 1'b0;
        if (mode_wr) begin
            s_d.pend_run   = s_q.pend_run   | wr_data[MB_RUN];
            s_d.pend_rsten = s_q.pend_rsten | wr_data[MB_RSTEN];
            if (!wr_data[MB_TOF]) s_d.tof = 1'b0;
        end
        if (const_wr) s_d.tc = (wr_data < TC_FLOOR) ? TC_FLOOR : wr_data;
        if (fire) begin
            s_d.run        = s_q.run   | s_q.pend_run;
            s_d.rsten      = s_q.rsten | s_q.pend_rsten;
            s_d.pend_run   = 1'b0;
            s_d.pend_rsten = 1'b0;
        end
        if (expire) begin
            s_d.tof   = 1'b1;
            s_d.intf  = 1'b1;
            s_d.run   = 1'b0;
            s_d.rsten = 1'b0;
            s_d.req   = s_q.rsten;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_por_n) begin
            s_q <= S_INIT;
        end else if (!rst_sys_n) begin
            s_q     <= S_INIT;
            s_q.tof <= s_q.tof;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        rd_data = '0;
        case (addr)
            ADDR_W'(OFS_MODE): begin
                rd_data[MB_RUN]   = s_q.run;
                rd_data[MB_RSTEN] = s_q.rsten;
                rd_data[MB_TOF]   = s_q.tof;
                rd_data[MB_INT]   = s_q.intf;
            end
            ADDR_W'(OFS_CONST): rd_data = s_q.tc;
            ADDR_W'(OFS_VALUE): rd_data = cnt;
            default:            rd_data = '0;
        endcase
    end

    assign irq          = s_q.intf;
    assign chip_rst_req = s_q.req;

    // R3: run only turns on as the result of a completed feed
    p_mode_held_r3: assert property (@(posedge clk) disable iff (clr_any)
        $rose(s_q.run) |-> $past(fire));
    // R4: run stays set until a timeout
    p_set_only_r4: assert property (@(posedge clk) disable iff (clr_any)
        (s_q.run && !expire) |=> s_q.run);
    // R6: a timeout always leaves the flag set
    p_tof_set_r6: assert property (@(posedge clk) disable iff (clr_any)
        expire |=> s_q.tof);
    // R7: the interrupt only goes away through a reset
    p_irq_sticky_r7: assert property (@(posedge clk) disable iff (clr_any)
        irq |=> irq);
    // R8: the reset request is a single-cycle pulse
    p_req_pulse_r8: assert property (@(posedge clk) disable iff (clr_any)
        chip_rst_req |=> !chip_rst_req);
    // R8: the request needs reset-enable in the cycle before
    p_req_gated_r8: assert property (@(posedge clk) disable iff (clr_any)
        chip_rst_req |-> $past(s_q.rsten));
    // R9: the constant never falls below its floor
    p_const_floor_r9: assert property (@(posedge clk) disable iff (clr_any)
        s_q.tc >= TC_FLOOR);
endmodule

// File: tb/sim_wdt_feed_ctrl.sv
module sim_wdt_feed_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_por_n = 1'b0;
    logic        rst_sys_n = 1'b0;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq;
    logic        chip_rst_req;

    int n_chk = 0;
    int n_bad = 0;
    int n_pulse = 0;

    // behavioural reference state
    int m_run, m_rsten, m_tof, m_intf, m_prun, m_prst, m_req, m_pre, m_armed;
    longint m_tc, m_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdt_feed_ctrl u0 (
        .clk(clk), .rst_por_n(rst_por_n), .rst_sys_n(rst_sys_n), .addr(addr),
        .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data), .rd_data(rd_data),
        .irq(irq), .chip_rst_req(chip_rst_req)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        bit fire, expire, tick;
        if (!rst_por_n || !rst_sys_n) begin
            if (!rst_por_n) m_tof = 0;
            m_run = 0; m_rsten = 0; m_intf = 0; m_prun = 0; m_prst = 0;
            m_req = 0; m_pre = 0; m_armed = 0; m_tc = 255; m_cnt = 255;
        end else begin
            fire   = wr_en && addr == 8 && m_armed != 0 && wr_data[7:0] == 8'h55;
            tick   = (m_pre == 3);
            expire = m_run != 0 && tick && m_cnt == 0 && !fire;
            m_pre  = (m_pre + 1) % 4;
            if (wr_en || rd_en) m_armed = (wr_en && addr == 8 && wr_data[7:0] == 8'hAA) ? 1 : 0;
            m_req = 0;
            if (fire) m_cnt = m_tc;
            else if (expire) m_cnt = m_tc;
            else if (m_run != 0 && tick) m_cnt = m_cnt - 1;
            if (wr_en && addr == 0) begin
                if (wr_data[0]) m_prun = 1;
                if (wr_data[1]) m_prst = 1;
                if (!wr_data[2]) m_tof = 0;
            end
            if (wr_en && addr == 4) m_tc = (wr_data < 255) ? 255 : wr_data;
            if (fire) begin
                if (m_prun != 0) m_run = 1;
                if (m_prst != 0) m_rsten = 1;
                m_prun = 0; m_prst = 0;
            end
            if (expire) begin
                m_req = m_rsten; m_tof = 1; m_intf = 1; m_run = 0; m_rsten = 0;
            end
        end
    end

    // every-cycle comparison of the registered outputs
    always @(negedge clk) begin
        check("R7 irq", irq, m_intf);
        check("R8 chip_rst_req", chip_rst_req, m_req);
        if (chip_rst_req) n_pulse++;
    end

    function automatic longint exp_rd(input int a);
        case (a)
            0:  return longint'((m_intf << 3) | (m_tof << 2) | (m_rsten << 1) | m_run);
            4:  return m_tc;
            12: return m_cnt;
            default: return 0;
        endcase
    endfunction

    task automatic bus_wr(input int a, input logic [31:0] d);
        addr = 4'(a); wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input string tag, input int a);
        addr = 4'(a); rd_en = 1'b1;
        #1 check(tag, rd_data, exp_rd(a));
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired, run did not complete");
        finish_run();
    end

    initial begin
        idle(3);
        rst_por_n = 1'b1; rst_sys_n = 1'b1;
        idle(1);
        // R1 R9: reset values and map
        bus_rd("R1 mode reset", 0);
        bus_rd("R9 const reset", 4);
        bus_rd("R9 count reset", 12);
        bus_rd("R1 feed reads zero", 8);
        bus_rd("R1 unmapped reads zero", 6);
        // R9: floor on the constant
        bus_wr(4, 32'h10);
        bus_rd("R9 small constant floored", 4);
        bus_wr(4, 32'h120);
        bus_rd("R9 constant stored", 4);
        // R3: mode write held
        bus_wr(0, 32'h3);
        idle(2);
        bus_rd("R3 mode held before feed", 0);
        // R10: abandoned sequences
        bus_wr(8, 32'hAA);
        bus_rd("R10 read between keys", 12);
        bus_wr(8, 32'h55);
        bus_rd("R10 no reload after read", 0);
        bus_wr(8, 32'hAA);
        bus_wr(8, 32'h12);
        bus_wr(8, 32'h55);
        bus_rd("R10 wrong second key", 12);
        bus_rd("R10 mode still held", 0);
        // R2 R3: valid feed applies mode and reloads
        bus_wr(8, 32'hAA);
        idle(2);
        bus_wr(8, 32'h55);
        bus_rd("R3 mode applied after feed", 0);
        bus_rd("R2 reload value", 12);
        idle(37);
        bus_rd("R5 decrement", 12);
        // R4: enable bits cannot be cleared
        bus_wr(0, 32'h0);
        bus_wr(8, 32'hAA);
        bus_wr(8, 32'h55);
        bus_rd("R4 set-only after clear attempt", 0);
        bus_rd("R2 second reload", 12);
        // R5 R6 R7 R8: timeout with reset-enable
        idle(1300);
        bus_rd("R5 R6 R7 flags after timeout", 0);
        bus_rd("R5 reload on timeout", 12);
        check("R8 one pulse", n_pulse, 1);
        check("R7 irq high", irq, 1'b1);
        // R6: write 1 ignored, write 0 clears at once
        bus_wr(0, 32'h4);
        bus_rd("R6 write one ignored", 0);
        bus_wr(0, 32'hC);
        bus_wr(0, 32'h0);
        bus_rd("R6 cleared without feed", 0);
        check("R7 irq kept after flag writes", irq, 1'b1);
        // R8: timeout without reset-enable gives no pulse
        bus_wr(0, 32'h1);
        bus_wr(8, 32'hAA);
        bus_wr(8, 32'h55);
        bus_rd("R3 run only", 0);
        idle(1300);
        bus_rd("R6 flag set again", 0);
        check("R8 no extra pulse", n_pulse, 1);
        // R11: other reset keeps timeout flag
        bus_wr(4, 32'h300);
        rst_sys_n = 1'b0;
        idle(2);
        rst_sys_n = 1'b1;
        idle(1);
        bus_rd("R11 flag survives other reset", 0);
        bus_rd("R11 constant reset", 4);
        bus_rd("R11 count reset", 12);
        check("R7 irq cleared by reset", irq, 1'b0);
        // R11: power-on reset clears the flag
        rst_por_n = 1'b0;
        idle(2);
        rst_por_n = 1'b1;
        idle(1);
        bus_rd("R11 power-on clears flag", 0);
        idle(2);
        finish_run();
    end
endmodule